// File: doc/BRIEF.md
# Configurable Routing Switch Box

This block sits where a horizontal and a vertical routing channel cross. Each of its four sides (north, east, south, west) has an input bus and an output bus of `TRACKS` tracks. Every output track is driven by exactly one chosen input track on one of the other three sides, or is held at 0. An output never takes its value from its own side. The choice is a directional multiplexer, so no tristate wiring is involved.

The `TOPOLOGY` parameter fixes which links can exist. In planar form (0), a track joins only the track with the same number on another side. In the index-rotating form (1), straight-through links keep the track number, while turning links move to a neighbouring track number. The configuration bits only pick among the links that the topology allows; they can never add a link.

All configuration sits in one serial chain. It is loaded one bit per clock while the shift enable is high. The chain's last bit comes out on a pin, so several boxes can be chained in series. Routing is combinational, so an output follows its selected input in the same cycle.

Top module: `swbox_route`

## Requirements
- R1: While `rst_n` is low, every configuration bit is cleared, every output track reads 0 and `cfg_out` reads 0. A shift request made during reset leaves no trace after reset is released.
- R2: At each rising edge where `cfg_en` is high (from the second edge after reset release onward), the chain moves up one place. `cfg_in` enters bit 0 and `cfg_out` shows bit 47, the top of the 48-bit chain at defaults. A vector shifted in most-significant bit first therefore lands in place after 48 shifts, and it then emerges on `cfg_out` most-significant bit first.
- R3: While `cfg_en` is low, the chain holds its value. Toggling `cfg_in` changes neither `cfg_out` nor any output track.
- R4: Sides are numbered north=0, east=1, south=2, west=3. The output track t on side d has a 3-bit field at chain bits [3*(4d+t)+2 : 3*(4d+t)]: bit 2 is the enable and bits 1:0 are the source code. Code 0 takes its source from side (d+1) mod 4, code 1 from the opposite side (d+2) mod 4, and code 2 from side (d+3) mod 4. Code 3 drives 0.
- R5: An output whose enable bit is 0 drives 0, whatever its code and its inputs.
- R6: In planar topology, the source track of every link has the same number as the output track.
- R7: In the rotating topology, code 1 uses source track t. Code 0 uses track (t+1) mod 4 and code 2 uses track (t+3) mod 4.
- R8: An output changes in the same cycle as its selected input, with no register in the data path.
- R9: Input track 0 on the west side can reach output track 1 on the north side in the rotating topology (code 2), and never in planar topology.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (top of chain) |
| in_n | input | TRACKS | North side input tracks |
| in_e | input | TRACKS | East side input tracks |
| in_s | input | TRACKS | South side input tracks |
| in_w | input | TRACKS | West side input tracks |
| out_n | output | TRACKS | North side output tracks |
| out_e | output | TRACKS | East side output tracks |
| out_s | output | TRACKS | South side output tracks |
| out_w | output | TRACKS | West side output tracks |

## Verification
The stability property assumes that track inputs change only between clock edges. It also assumes they do not change in a cycle that is being compared with the previous one, so a change in an output can be traced either to an input change or to a shift. The bench drives every input a short delay after the rising edge and samples on the falling edge. The reachability properties hold for any input pattern. The reset property needs `rst_n` to be low at the first edge, and the bench holds it low from time zero.

// File: rtl/swbox_pkg.sv
`timescale 1ns/1ps
package swbox_pkg;

  localparam int SIDES   = 4;
  localparam int CODE_W  = 2;
  localparam int FIELD_W = CODE_W + 1;

  localparam int TOPO_PLANAR   = 0;
  localparam int TOPO_ROTATING = 1;

  typedef enum logic [CODE_W-1:0] {
    SRC_NEXT = 2'd0,
    SRC_OPP  = 2'd1,
    SRC_PREV = 2'd2,
    SRC_OFF  = 2'd3
  } src_code_e;

  typedef struct packed {
    logic      en;
    src_code_e code;
  } route_field_t;

  // Track number feeding output track t for a given source code.
  function automatic int src_track(input int topo, input int code,
                                   input int t, input int tracks);
    if (topo == TOPO_ROTATING && code == 0) return (t + 1) % tracks;
    if (topo == TOPO_ROTATING && code == 2) return (t + tracks - 1) % tracks;
    return t;
  endfunction

endpackage

// File: rtl/swbox_rst_sync.sv
`timescale 1ns/1ps
module swbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[1];
endmodule

// File: rtl/swbox_cfg_chain.sv
`timescale 1ns/1ps
module swbox_cfg_chain #(
  parameter int LEN = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           shift_en,
  input  logic           ser_in,
  output logic           ser_out,
  output logic [LEN-1:0] bits
);
  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;
  logic           shift_ce;

  assign shift_ce = run & shift_en;

  always_comb begin
    chain_d = chain_q;
    if (shift_ce) chain_d = {chain_q[LEN-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign bits    = chain_q;
  assign ser_out = chain_q[LEN-1];
endmodule

// File: rtl/swbox_track_sel.sv
`timescale 1ns/1ps
module swbox_track_sel
  import swbox_pkg::*;
(
  input  route_field_t field,
  input  logic [2:0]   src,
  output logic         drv
);
  always_comb begin
    drv = 1'b0;
    if (field.en) begin
      unique case (field.code)
        SRC_NEXT: drv = src[0];
        SRC_OPP:  drv = src[1];
        SRC_PREV: drv = src[2];
        SRC_OFF:  drv = 1'b0;
        default:  drv = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/swbox_route.sv
`timescale 1ns/1ps
module swbox_route #(
  parameter int TRACKS   = 4,
  parameter int TOPOLOGY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_in,
  output logic              cfg_out,
  input  logic [TRACKS-1:0] in_n,
  input  logic [TRACKS-1:0] in_e,
  input  logic [TRACKS-1:0] in_s,
  input  logic [TRACKS-1:0] in_w,
  output logic [TRACKS-1:0] out_n,
  output logic [TRACKS-1:0] out_e,
  output logic [TRACKS-1:0] out_s,
  output logic [TRACKS-1:0] out_w
);
  import swbox_pkg::*;

  localparam int NUM_OUT   = SIDES * TRACKS;
  localparam int CHAIN_LEN = NUM_OUT * FIELD_W;

  logic                             run_q;
  logic [CHAIN_LEN-1:0]             cfg_q;
  logic [SIDES-1:0][TRACKS-1:0]     side_in;
  logic [SIDES-1:0][TRACKS-1:0]     side_out;

  assign side_in[0] = in_n;
  assign side_in[1] = in_e;
  assign side_in[2] = in_s;
  assign side_in[3] = in_w;

  assign out_n = side_out[0];
  assign out_e = side_out[1];
  assign out_s = side_out[2];
  assign out_w = side_out[3];

  swbox_rst_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q)
  );

  swbox_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .ser_out  (cfg_out),
    .bits     (cfg_q)
  );

  for (genvar d = 0; d < SIDES; d++) begin : g_side
    localparam int S_NXT = (d + 1) % SIDES;
    localparam int S_OPP = (d + 2) % SIDES;
    localparam int S_PRV = (d + 3) % SIDES;
    for (genvar t = 0; t < TRACKS; t++) begin : g_trk
      localparam int I_NXT = src_track(TOPOLOGY, 0, t, TRACKS);
      localparam int I_OPP = src_track(TOPOLOGY, 1, t, TRACKS);
      localparam int I_PRV = src_track(TOPOLOGY, 2, t, TRACKS);
      localparam int F_LO  = FIELD_W * (d * TRACKS + t);

      logic [2:0]   src;
      route_field_t fld;

      assign src = {side_in[S_PRV][I_PRV], side_in[S_OPP][I_OPP],
                    side_in[S_NXT][I_NXT]};
      assign fld = route_field_t'(cfg_q[F_LO +: FIELD_W]);

      swbox_track_sel u_sel (
        .field (fld),
        .src   (src),
        .drv   (side_out[d][t])
      );
    end
  end
endmodule

// File: rtl/swbox_route_chk.sv
`timescale 1ns/1ps
module swbox_route_chk #(
  parameter int TRACKS   = 4,
  parameter int TOPOLOGY = 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          run,
  input logic                          cfg_en,
  input logic                          cfg_out,
  input logic [4*TRACKS*3-1:0]         cfg_q,
  input logic [3:0][TRACKS-1:0]        side_in,
  input logic [3:0][TRACKS-1:0]        side_out
);
  import swbox_pkg::*;
  localparam int LEN = 4 * TRACKS * 3;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (side_out == '0 && cfg_out == 1'b0)); // R1

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cfg_en) |=> (cfg_out == $past(cfg_q[LEN-2]))); // R2

  AST_HOLD_SER: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_out)); // R3

  AST_HOLD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_en) && $stable(side_in)) |-> $stable(side_out)); // R3

  for (genvar d = 0; d < 4; d++) begin : g_d
    for (genvar t = 0; t < TRACKS; t++) begin : g_t
      localparam int I_NXT = src_track(TOPOLOGY, 0, t, TRACKS);
      localparam int I_PRV = src_track(TOPOLOGY, 2, t, TRACKS);
      if (TOPOLOGY == TOPO_PLANAR) begin : g_pl
        AST_PLANAR_REACH: assert property (@(posedge clk) disable iff (!rst_n)
          side_out[d][t] |-> (side_in[(d+1)%4][t] || side_in[(d+2)%4][t] ||
                              side_in[(d+3)%4][t])); // R6
      end else begin : g_rot
        AST_ROTATE_REACH: assert property (@(posedge clk) disable iff (!rst_n)
          side_out[d][t] |-> (side_in[(d+1)%4][I_NXT] || side_in[(d+2)%4][t] ||
                              side_in[(d+3)%4][I_PRV])); // R7
      end
    end
  end
endmodule

bind swbox_route swbox_route_chk #(.TRACKS(TRACKS), .TOPOLOGY(TOPOLOGY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_q),
  .cfg_en   (cfg_en),
  .cfg_out  (cfg_out),
  .cfg_q    (cfg_q),
  .side_in  (side_in),
  .side_out (side_out)
);

// File: tb/sim_swbox_route.sv
`timescale 1ns/1ps
module sim_swbox_route;
  localparam int LEN = 48;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_en, cfg_in;
  logic [3:0] in_n, in_e, in_s, in_w;
  logic [3:0] a_n, a_e, a_s, a_w, b_n, b_e, b_s, b_w;
  logic a_co, b_co;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit m_live = 0;
  bit cmp_on = 0;
  logic [LEN-1:0] m_chain;

  swbox_route #(.TRACKS(4), .TOPOLOGY(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(a_co),
    .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
    .out_n(a_n), .out_e(a_e), .out_s(a_s), .out_w(a_w));

  swbox_route #(.TRACKS(4), .TOPOLOGY(0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(b_co),
    .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
    .out_n(b_n), .out_e(b_e), .out_s(b_s), .out_w(b_w));

  // Reference chain: only shifts once the bench declares the box live.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_chain <= '0;
    else if (m_live && cfg_en) m_chain <= {m_chain[LEN-2:0], cfg_in};
  end

  function automatic logic [3:0] side_val(int s);
    case (s)
      0: return in_n;
      1: return in_e;
      2: return in_s;
      default: return in_w;
    endcase
  endfunction

  function automatic logic [3:0] got_side(int dut, int s);
    if (dut == 0) begin
      case (s) 0: return a_n; 1: return a_e; 2: return a_s; default: return a_w; endcase
    end
    case (s) 0: return b_n; 1: return b_e; 2: return b_s; default: return b_w; endcase
  endfunction

  // rotating: 1 = turning links move the track number
  function automatic logic [3:0] exp_side(bit rotating, int s);
    logic [3:0] r = '0;
    for (int t = 0; t < 4; t++) begin
      logic [2:0] f = m_chain[3*(4*s+t) +: 3];
      int code = f[1:0];
      int from = (s + code + 1) % 4;
      int idx = t;
      if (rotating && code == 0) idx = (t + 1) % 4;
      if (rotating && code == 2) idx = (t + 3) % 4;
      if (f[2] && code != 3) r[t] = side_val(from) >> idx;
    end
    return r;
  endfunction

  function automatic logic [LEN-1:0] put(logic [LEN-1:0] v, int s, int t, bit en, int code);
    logic [LEN-1:0] r = v;
    r[3*(4*s+t) +: 3] = {en, code[1:0]};
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Per-cycle comparison against the reference (R8 routes, R2 serial out).
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int s = 0; s < 4; s++) begin
        check("R8 rotating route", got_side(0, s), exp_side(1'b1, s));
        check("R8 planar route", got_side(1, s), exp_side(1'b0, s));
      end
      check("R2 cfg_out rotating", a_co, m_chain[LEN-1]);
      check("R2 cfg_out planar", b_co, m_chain[LEN-1]);
    end
  end

  task automatic load(logic [LEN-1:0] v);
    for (int i = LEN - 1; i >= 0; i--) begin
      cfg_in = v[i];
      cfg_en = 1'b1;
      @(posedge clk); #2;
    end
    cfg_en = 1'b0;
    cfg_in = 1'b0;
  endtask

  task automatic drive(logic [3:0] n, logic [3:0] e, logic [3:0] s, logic [3:0] w);
    in_n = n; in_e = e; in_s = s; in_w = w;
  endtask

  initial begin
    logic [LEN-1:0] v;
    logic [15:0] snap;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_in = 1'b0;
    drive(4'h0, 4'h0, 4'h0, 4'h0);
    repeat (2) @(posedge clk); #2;
    cmp_on = 1;

    // R1: shift attempts during reset are dropped
    cfg_en = 1'b1; cfg_in = 1'b1;
    drive(4'hF, 4'hF, 4'hF, 4'hF);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", {a_n, a_e, a_s, a_w}, 16'h0);
    check("R1 reset cfg_out", a_co, 1'b0);
    @(posedge clk); #2;
    cfg_en = 1'b0; cfg_in = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #2;
    m_live = 1;
    @(negedge clk);
    check("R1 after release", {a_n, a_e, a_s, a_w, b_n, b_e, b_s, b_w}, 32'h0);
    @(posedge clk); #2;

    // R4: all straight-through links
    v = '0;
    for (int s = 0; s < 4; s++) for (int t = 0; t < 4; t++) v = put(v, s, t, 1'b1, 1);
    load(v);
    drive(4'h1, 4'h6, 4'h9, 4'hC);
    @(negedge clk);
    check("R4 north from south", a_n, 4'h9);
    check("R4 east from west planar", b_e, 4'hC);
    check("R8 same-cycle follow", b_w, 4'h6);
    @(posedge clk); #2;

    // R9 / R6: west track 0 to north track 1
    v = put('0, 0, 1, 1'b1, 2);
    load(v);
    drive(4'h0, 4'h0, 4'h0, 4'h1);
    @(negedge clk);
    check("R9 rotating turn 0->1", a_n, 4'h2);
    check("R9 planar no turn 0->1", b_n, 4'h0);
    @(posedge clk); #2;
    drive(4'h0, 4'h0, 4'h0, 4'h2);
    @(negedge clk);
    check("R6 planar same index", b_n, 4'h2);
    check("R7 rotating ignores same index", a_n, 4'h0);
    @(posedge clk); #2;

    // R7: code 0 on north track 0 pulls east track 1
    v = put('0, 0, 0, 1'b1, 0);
    load(v);
    drive(4'h0, 4'h2, 4'h0, 4'h0);
    @(negedge clk);
    check("R7 rotating next-side index", a_n, 4'h1);
    check("R6 planar next-side index", b_n, 4'h0);
    @(posedge clk); #2;

    // R5 / R4: disabled field and code 3 drive 0
    v = '0;
    for (int t = 0; t < 4; t++) v = put(v, 1, t, 1'b0, 1);
    for (int t = 0; t < 4; t++) v = put(v, 2, t, 1'b1, 3);
    load(v);
    drive(4'hF, 4'hF, 4'hF, 4'hF);
    @(negedge clk);
    check("R5 disabled drives 0", {a_e, b_e}, 8'h0);
    check("R4 code 3 drives 0", {a_s, b_s}, 8'h0);
    @(posedge clk); #2;

    // R3: hold while cfg_en low
    v = {$urandom, $urandom};
    load(v);
    @(negedge clk);
    snap = {a_n, a_e, a_s, a_w};
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #2;
      cfg_in = ~cfg_in;
    end
    @(negedge clk);
    check("R3 outputs held", {a_n, a_e, a_s, a_w}, snap);
    check("R3 cfg_out held", a_co, v[LEN-1]);
    @(posedge clk); #2;
    cfg_in = 1'b0;

    // R2: loaded vector streams out MSB first
    cfg_en = 1'b1;
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      check("R2 chain stream", a_co, v[LEN-1-i]);
      @(posedge clk); #2;
    end
    cfg_en = 1'b0;

    // R8: random configurations and traffic
    for (int k = 0; k < 30; k++) begin
      load({$urandom, $urandom});
      for (int j = 0; j < 5; j++) begin
        drive(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
        @(posedge clk); #2;
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule